// File: doc/BRIEF.md
# Frame-Synchronized Shadow Register Bank

This block holds the control registers of a video capture front end. It separates what the host writes from what the capture hardware uses. A host register port writes a control word and a base address. Readback shows each write from the very next cycle. Each hardware-facing field has a second, working copy, and that copy is loaded only at a video timing event chosen for that field.

Three fields are double-buffered, and each has its own trigger. The capture enable loads at frame start. Frame start is an edge of the vertical sync input, and a polarity input selects which edge. The output base address loads either at frame start or on a first-active-pixel strobe, depending on a mode bit in the control word. The byte-swap control tracks the host value only while vertical sync is at its active level.

The vertical sync input is brought into the clock domain through a two-stage synchronizer and then edge-detected. The block has no data stream, so there is no valid/ready interface and no back-pressure to describe. Every pin is a plain control or status signal. The register port has no handshake: a write is taken whenever the write strobe is high at a clock edge.

Top module: `frame_shadow_regs`

## Requirements
- R1: After reset, every host register, every working copy and `busy` are zero, and reads of the control (address 0), base (address 1) and status (address 2) registers return 0.
- R2: A host write is visible on `reg_rdata` from the cycle after the write edge. The read data is combinational in `reg_addr`. The control word uses bit 0 = capture enable, bit 1 = address mode, bit 2 = byte swap. The status word has bit 0 = busy. Unmapped addresses read as 0.
- R3: `cap_en_act` changes only at frame start. With `vsync_pol`=1, frame start is a rising edge of `vsync_in`; with `vsync_pol`=0, it is a falling edge. The new value is seen on the third rising clock edge after the transition on `vsync_in`.
- R4: Clearing the capture enable in the middle of a frame leaves `cap_en_act` at 1 until the next frame start, so the frame in progress completes.
- R5: With address mode 0, `base_addr_act` loads the host base address at frame start and holds it at all other times.
- R6: With address mode 1, `base_addr_act` ignores frame start and loads on the clock edge where `first_pix_stb` is high.
- R7: Bits 4..0 of the base address are discarded on write. They read as zero and are zero in `base_addr_act`.
- R8: `byte_swap_act` follows the host swap bit only while the synchronized vertical sync is at its active level (high for `vsync_pol`=1, low for `vsync_pol`=0). Outside that level it holds.
- R9: `busy` is 1 exactly when `cap_en_act` is 1 and the synchronized vertical sync is at its active level.
- R10: If a host write lands on the same edge as a load of a working copy, that copy takes the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| vsync_in | input | 1 | Vertical sync, asynchronous to `clk` |
| vsync_pol | input | 1 | 1 = active-high sync, 0 = active-low |
| first_pix_stb | input | 1 | One-cycle pulse when the first active pixel of the start line is reached |
| cap_en_act | output | 1 | Working capture enable |
| base_addr_act | output | 32 | Working output base address |
| byte_swap_act | output | 1 | Working byte-swap control |
| busy | output | 1 | Capture of a frame in progress |

## Verification
Readback is due one cycle after a write edge. Loads driven by vertical sync are due on the third clock edge after the input changes: two synchronizer stages, then the load register. Loads from the pixel strobe are due on the edge that samples the strobe. A behavioural model in the bench steps on each rising edge with the same latencies and is compared at every falling edge. The bench drives inputs just after the falling edge, so every sample falls halfway between edges. Directed checks wait exactly those edge counts, and the collision case places a write on the one edge where the frame-start pulse is high.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  localparam int CTRL_ADDR = 0;
  localparam int BASE_ADDR = 1;
  localparam int STAT_ADDR = 2;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_SWAP_BIT = 2;
  localparam int STAT_BUSY_BIT = 0;
endpackage

// File: rtl/shreg_vsync.sv
module shreg_vsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_in,
  input  logic pol,
  output logic frame_start,
  output logic vs_active
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= vs_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
    end
  end

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;

  assign frame_start = pol ? (lvl & ~prev_q) : (~lvl & prev_q);
  assign vs_active   = pol ? lvl : ~lvl;

  // R3
  fs_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R3
  fs_at_active_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> vs_active);
endmodule

// File: rtl/shreg_field.sv
module shreg_field #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] host_val,
  output logic [W-1:0] act
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    act <= '0;
    else if (load) act <= wr_hit ? wr_val : host_val;

  // R10
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act));
endmodule

// File: rtl/frame_shadow_regs.sv
module frame_shadow_regs #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int ALIGN_BITS  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              vsync_in,
  input  logic              vsync_pol,
  input  logic              first_pix_stb,
  output logic              cap_en_act,
  output logic [DATA_W-1:0] base_addr_act,
  output logic              byte_swap_act,
  output logic              busy
);
  import shreg_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam int               HI_W   = DATA_W - ALIGN_BITS;

  logic            en_h, mode_h, swap_h;
  logic [HI_W-1:0] base_hi_h;
  logic [HI_W-1:0] base_hi_act;
  logic            wr_ctrl, wr_base;
  logic            frame_start, vs_active;
  logic            base_load;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_base = reg_wr && (reg_addr == A_BASE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_h      <= 1'b0;
      mode_h    <= 1'b0;
      swap_h    <= 1'b0;
      base_hi_h <= '0;
    end else begin
      if (wr_ctrl) begin
        en_h   <= reg_wdata[CTRL_EN_BIT];
        mode_h <= reg_wdata[CTRL_MODE_BIT];
        swap_h <= reg_wdata[CTRL_SWAP_BIT];
      end
      if (wr_base) base_hi_h <= reg_wdata[DATA_W-1:ALIGN_BITS];
    end

  shreg_vsync #(.STAGES(SYNC_STAGES)) u_vs (
    .clk(clk), .rst_n(rst_n), .vs_in(vsync_in), .pol(vsync_pol),
    .frame_start(frame_start), .vs_active(vs_active)
  );

  assign base_load = mode_h ? first_pix_stb : frame_start;

  shreg_field #(.W(1)) u_en (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .wr_hit(wr_ctrl),
    .wr_val(reg_wdata[CTRL_EN_BIT]), .host_val(en_h), .act(cap_en_act)
  );

  shreg_field #(.W(1)) u_swap (
    .clk(clk), .rst_n(rst_n), .load(vs_active), .wr_hit(wr_ctrl),
    .wr_val(reg_wdata[CTRL_SWAP_BIT]), .host_val(swap_h), .act(byte_swap_act)
  );

  shreg_field #(.W(HI_W)) u_base (
    .clk(clk), .rst_n(rst_n), .load(base_load), .wr_hit(wr_base),
    .wr_val(reg_wdata[DATA_W-1:ALIGN_BITS]), .host_val(base_hi_h), .act(base_hi_act)
  );

  assign base_addr_act = {base_hi_act, {ALIGN_BITS{1'b0}}};
  assign busy          = cap_en_act & vs_active;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CTRL_EN_BIT]   = en_h;
        reg_rdata[CTRL_MODE_BIT] = mode_h;
        reg_rdata[CTRL_SWAP_BIT] = swap_h;
      end
      A_BASE:  reg_rdata = {base_hi_h, {ALIGN_BITS{1'b0}}};
      A_STAT:  reg_rdata[STAT_BUSY_BIT] = busy;
      default: reg_rdata = '0;
    endcase
  end

  // R3
  en_moves_on_frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_en_act) |-> $past(frame_start));

  // R8
  swap_moves_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_swap_act) |-> $past(vs_active));

  // R6
  base_moves_on_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(base_addr_act) && $past(mode_h)) |-> $past(first_pix_stb));
endmodule

// File: tb/frame_shadow_regs_tb.sv
module frame_shadow_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        vsync_in = 1'b0;
  logic        vsync_pol = 1'b1;
  logic        first_pix_stb = 1'b0;
  logic        cap_en_act, byte_swap_act, busy;
  logic [31:0] base_addr_act;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  frame_shadow_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vsync_in(vsync_in),
    .vsync_pol(vsync_pol), .first_pix_stb(first_pix_stb),
    .cap_en_act(cap_en_act), .base_addr_act(base_addr_act),
    .byte_swap_act(byte_swap_act), .busy(busy)
  );

  // behavioural reference model, stepped on each rising edge
  bit          m_s1, m_s2, m_s3;
  bit          m_en_h, m_mode_h, m_swap_h;
  bit [31:0]   m_base_h;
  bit          m_en_a, m_swap_a;
  bit [31:0]   m_base_a;

  always @(posedge clk or negedge rst_n) begin
    bit fs, lvl, wc, wb, n_en, n_mode, n_swap;
    bit [31:0] n_base;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_en_h = 0; m_mode_h = 0; m_swap_h = 0; m_base_h = 0;
      m_en_a = 0; m_swap_a = 0; m_base_a = 0;
    end else begin
      fs  = vsync_pol ? (m_s2 && !m_s3) : (!m_s2 && m_s3);
      lvl = vsync_pol ? m_s2 : !m_s2;
      wc  = reg_wr && reg_addr == 2'd0;
      wb  = reg_wr && reg_addr == 2'd1;
      n_en   = wc ? reg_wdata[0] : m_en_h;
      n_mode = wc ? reg_wdata[1] : m_mode_h;
      n_swap = wc ? reg_wdata[2] : m_swap_h;
      n_base = wb ? (reg_wdata & 32'hFFFF_FFE0) : m_base_h;
      if (fs)  m_en_a   = n_en;
      if (lvl) m_swap_a = n_swap;
      if (m_mode_h ? first_pix_stb : fs) m_base_a = n_base;
      m_en_h = n_en; m_mode_h = n_mode; m_swap_h = n_swap; m_base_h = n_base;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = vsync_in;
    end
  end

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // continuous comparison at every falling edge
  always @(negedge clk) begin
    bit mb;
    bit [31:0] mr;
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
    if (rst_n) begin
      mb = m_en_a && (vsync_pol ? m_s2 : !m_s2);
      case (reg_addr)
        2'd0: mr = {29'd0, m_swap_h, m_mode_h, m_en_h};
        2'd1: mr = m_base_h;
        2'd2: mr = {31'd0, mb};
        default: mr = 0;
      endcase
      cmp("R3 cap_en_act", {31'd0, cap_en_act}, {31'd0, m_en_a});
      cmp("R5 base_addr_act", base_addr_act, m_base_a);
      cmp("R8 byte_swap_act", {31'd0, byte_swap_act}, {31'd0, m_swap_a});
      cmp("R9 busy", {31'd0, busy}, {31'd0, mb});
      cmp("R2 reg_rdata", reg_rdata, mr);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    cmp(req, reg_rdata, exp);
    #1;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset values
    cmp("R1 cap_en_act", {31'd0, cap_en_act}, 0);
    cmp("R1 base_addr_act", base_addr_act, 0);
    cmp("R1 busy", {31'd0, busy}, 0);
    rd_chk("R1 ctrl read", 2'd0, 0);
    rd_chk("R1 base read", 2'd1, 0);
    rd_chk("R1 status read", 2'd2, 0);

    // R2 readback, R3 positive-polarity frame start
    wr(2'd0, 32'h1);
    rd_chk("R2 ctrl readback", 2'd0, 32'h1);
    cmp("R3 no load before frame start", {31'd0, cap_en_act}, 0);
    vsync_in = 1;
    step(2);
    cmp("R3 not yet after two edges", {31'd0, cap_en_act}, 0);
    @(negedge clk);
    cmp("R3 loaded on third edge", {31'd0, cap_en_act}, 1);
    cmp("R9 busy during active frame", {31'd0, busy}, 1);
    rd_chk("R9 status busy bit", 2'd2, 32'h1);

    // R4 clear mid frame
    wr(2'd0, 32'h0);
    step(5);
    cmp("R4 enable held mid frame", {31'd0, cap_en_act}, 1);
    cmp("R4 busy held mid frame", {31'd0, busy}, 1);
    vsync_in = 0;
    step(4);
    cmp("R9 busy drops outside active", {31'd0, busy}, 0);
    cmp("R4 enable held to next frame", {31'd0, cap_en_act}, 1);
    vsync_in = 1;
    step(4);
    cmp("R4 enable cleared at next frame", {31'd0, cap_en_act}, 0);

    // R5 / R7 base address, mode 0
    wr(2'd1, 32'h1234_567F);
    rd_chk("R7 low bits read zero", 2'd1, 32'h1234_5660);
    cmp("R5 base held before frame start", base_addr_act, 0);
    vsync_in = 0;
    step(4);
    vsync_in = 1;
    step(4);
    cmp("R5 base loaded at frame start", base_addr_act, 32'h1234_5660);
    cmp("R7 working low bits zero", {27'd0, base_addr_act[4:0]}, 0);

    // R6 mode 1
    wr(2'd0, 32'h2);
    wr(2'd1, 32'hABCD_0040);
    vsync_in = 0;
    step(4);
    vsync_in = 1;
    step(4);
    cmp("R6 frame start ignored in mode 1", base_addr_act, 32'h1234_5660);
    first_pix_stb = 1;
    step(1);
    first_pix_stb = 0;
    cmp("R6 loaded on pixel strobe", base_addr_act, 32'hABCD_0040);

    // R8 swap only during active level
    vsync_in = 0;
    step(4);
    wr(2'd0, 32'h6);
    step(5);
    cmp("R8 swap held while inactive", {31'd0, byte_swap_act}, 0);
    vsync_in = 1;
    step(2);
    cmp("R8 swap not yet", {31'd0, byte_swap_act}, 0);
    step(1);
    cmp("R8 swap follows in active", {31'd0, byte_swap_act}, 1);

    // R3 negative polarity: falling edge is frame start
    wr(2'd0, 32'h1);
    vsync_pol = 0;
    step(4);
    cmp("R3 no load on rising edge for pol 0", {31'd0, cap_en_act}, 0);
    vsync_in = 0;
    step(3);
    cmp("R3 falling edge loads for pol 0", {31'd0, cap_en_act}, 1);
    wr(2'd0, 32'h4);
    step(2);
    cmp("R8 swap follows while low for pol 0", {31'd0, byte_swap_act}, 1);

    // R10 write colliding with frame start
    vsync_in = 1;
    step(4);
    vsync_pol = 1;
    wr(2'd0, 32'h0);
    vsync_in = 0;
    step(4);
    wr(2'd0, 32'h0);
    vsync_in = 1;
    step(2);
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'h1;
    step(1);
    reg_wr = 0;
    cmp("R10 collision takes written value", {31'd0, cap_en_act}, 1);
    step(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule